// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host reach a private 8-bit register space inside a PHY through only two host-visible registers. A command register holds the PHY offset, a direction flag and a read-only busy flag; a data register carries the byte to be written or the byte that came back. The host loads the data register, then writes the command register. That write starts one transaction on a simple request/acknowledge PHY port.

While the transaction runs the busy flag reads high, and the host polls it. Once busy falls, a read leaves the returned byte in the data register. Command writes that arrive while a transaction is running are dropped, so polling software cannot disturb the access in flight. The host side is a single-cycle write strobe with a combinational read port.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, busy is low, `phy_req` is low, and both the command register (host offset 0x300) and the data register (host offset 0x304) read as zero.
- R2: The command register at 0x300 reads back as offset in bits 7:0, write flag in bit 8, busy in bit 9 and zeros above. Any other host offset reads as zero.
- R3: A host write to 0x304 stores bits 7:0 of the written word. Bits 15:8 of the data register always read as zero.
- R4: A host write to 0x300 while idle with bit 8 set starts a PHY write. In the next cycle `phy_req`=1, `phy_we`=1, `phy_addr` equals the written bits 7:0, and `phy_wdata` equals the data register. The value written to bit 9 has no effect.
- R5: A host write to 0x300 while idle with bit 8 clear starts a PHY read. In the next cycle `phy_req`=1, `phy_we`=0, and `phy_addr` equals the written bits 7:0.
- R6: From launch until `phy_ack`, busy stays high and `phy_req`, `phy_we`, `phy_addr` and `phy_wdata` hold their values.
- R7: In the cycle after the one in which `phy_ack` is sampled high, busy and `phy_req` are both low.
- R8: When a read finishes, the data register holds the `phy_rdata` byte that was sampled with `phy_ack`.
- R9: A host write to 0x300 while busy is high is ignored. The running transaction's offset and direction stay the same, no extra PHY access takes place, and the command register keeps its value.
- R10: The write data is taken at launch. A host write to 0x304 during a running write changes the data register but does not change `phy_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational on host_addr) |
| phy_req | output | 1 | PHY transaction request, held until ack |
| phy_we | output | 1 | PHY transaction is a write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write byte |
| phy_ack | input | 1 | PHY completion strobe |
| phy_rdata | input | 8 | PHY read byte, valid with ack |

## Verification
The bench runs writes followed by reads of the same offset, so a byte that reaches the wrong offset or is never captured shows up as a data mismatch. It also reads offsets that were never written, including 0x00 and 0xFF, which separates real capture from stale data left in the register. The PHY model's acknowledge latency is varied from zero to several cycles, which tests both the hold-until-ack behaviour and the one-cycle busy drop. Command writes and data writes issued during a running transaction check that the access in flight is protected: its offset, direction and write byte must not change.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
    localparam int HOST_AW  = 12;
    localparam int HOST_DW  = 16;
    localparam int PHY_AW   = 8;
    localparam int PHY_DW   = 8;
    localparam int WE_BIT   = PHY_AW;
    localparam int BUSY_BIT = PHY_AW + 1;

    localparam logic [HOST_AW-1:0] CMD_OFS = 12'h300;
    localparam logic [HOST_AW-1:0] DAT_OFS = 12'h304;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_DAT
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } xact_state_e;

    typedef struct packed {
        logic              we;
        logic [PHY_AW-1:0] addr;
        logic [PHY_DW-1:0] wdata;
    } phy_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [HOST_AW-1:0] a);
        if (a == CMD_OFS)      return SEL_CMD;
        else if (a == DAT_OFS) return SEL_DAT;
        else                   return SEL_NONE;
    endfunction

    function automatic logic [HOST_DW-1:0] pack_cmd(input logic busy,
                                                   input logic we,
                                                   input logic [PHY_AW-1:0] ofs);
        logic [HOST_DW-1:0] v;
        v = '0;
        v[PHY_AW-1:0] = ofs;
        v[WE_BIT]     = we;
        v[BUSY_BIT]   = busy;
        return v;
    endfunction
endpackage

// File: rtl/bridge_host_regs.sv
module bridge_host_regs
    import phy_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               busy,
    input  logic               cap_valid,
    input  logic [PHY_DW-1:0]  cap_data,
    output logic               launch,
    output phy_cmd_t           launch_cmd,
    output logic [PHY_DW-1:0]  data_q
);
    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic              cmd_we_q;
    logic [PHY_AW-1:0] cmd_ofs_q;
    logic              host_wr;

    assign host_wr = host_valid && host_write;
    assign wsel    = decode_sel(host_addr);
    assign rsel    = decode_sel(host_addr);
    assign launch  = host_wr && (wsel == SEL_CMD) && !busy;

    assign launch_cmd.we    = host_wdata[WE_BIT];
    assign launch_cmd.addr  = host_wdata[PHY_AW-1:0];
    assign launch_cmd.wdata = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_we_q  <= 1'b0;
            cmd_ofs_q <= '0;
        end else if (launch) begin
            cmd_we_q  <= host_wdata[WE_BIT];
            cmd_ofs_q <= host_wdata[PHY_AW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (cap_valid) begin
            data_q <= cap_data;
        end else if (host_wr && wsel == SEL_DAT) begin
            data_q <= host_wdata[PHY_DW-1:0];
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (rsel)
            SEL_CMD:  host_rdata = pack_cmd(busy, cmd_we_q, cmd_ofs_q);
            SEL_DAT:  host_rdata[PHY_DW-1:0] = data_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bridge_xact_engine.sv
module bridge_xact_engine
    import phy_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  phy_cmd_t          launch_cmd,
    input  logic              phy_ack,
    input  logic [PHY_DW-1:0] phy_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    output logic              busy,
    output logic              cap_valid,
    output logic [PHY_DW-1:0] cap_data
);
    xact_state_e state_q;
    phy_cmd_t    cmd_q;
    logic        done;

    assign done = (state_q == ST_WAIT) && phy_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    state_q <= ST_WAIT;
                    cmd_q   <= launch_cmd;
                end
                ST_WAIT: if (phy_ack) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == ST_WAIT);
    assign phy_req   = busy;
    assign phy_we    = cmd_q.we;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.wdata;
    assign cap_valid = done && !cmd_q.we;
    assign cap_data  = phy_rdata;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
    import phy_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PHY_AW-1:0]  phy_addr,
    output logic [PHY_DW-1:0]  phy_wdata,
    input  logic               phy_ack,
    input  logic [PHY_DW-1:0]  phy_rdata
);
    logic              busy;
    logic              cap_valid;
    logic [PHY_DW-1:0] cap_data;
    logic              launch;
    phy_cmd_t          launch_cmd;
    logic [PHY_DW-1:0] data_q;

    bridge_host_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .cap_valid  (cap_valid),
        .cap_data   (cap_data),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .data_q     (data_q)
    );

    bridge_xact_engine i_engine (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_cmd (launch_cmd),
        .phy_ack    (phy_ack),
        .phy_rdata  (phy_rdata),
        .phy_req    (phy_req),
        .phy_we     (phy_we),
        .phy_addr   (phy_addr),
        .phy_wdata  (phy_wdata),
        .busy       (busy),
        .cap_valid  (cap_valid),
        .cap_data   (cap_data)
    );
endmodule

// File: rtl/phy_bridge_checker.sv
module phy_bridge_checker
    import phy_bridge_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               host_valid,
    input logic               host_write,
    input logic [HOST_AW-1:0] host_addr,
    input logic [HOST_DW-1:0] host_wdata,
    input logic [HOST_DW-1:0] host_rdata,
    input logic               phy_req,
    input logic               phy_we,
    input logic [PHY_AW-1:0]  phy_addr,
    input logic [PHY_DW-1:0]  phy_wdata,
    input logic               phy_ack,
    input logic [PHY_DW-1:0]  phy_rdata,
    input logic               busy,
    input logic [PHY_DW-1:0]  data_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && !phy_req && data_q == '0));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (host_addr == DAT_OFS) |-> (host_rdata[HOST_DW-1:PHY_DW] == '0));

    p_launch_r4: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_write && host_addr == CMD_OFS && !busy) |=>
        (phy_req && phy_addr == $past(host_wdata[PHY_AW-1:0])
                 && phy_we == $past(host_wdata[WE_BIT])));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=>
        (phy_req && busy && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack) |=> (!phy_req && !busy));

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack && !phy_we) |=> (data_q == $past(phy_rdata)));
endmodule

bind phy_reg_bridge phy_bridge_checker i_chk (.*);

// File: tb/test_phy_reg_bridge.sv
module test_phy_reg_bridge;
    import phy_bridge_pkg::*;

    typedef struct {
        logic       we;
        logic [7:0] addr;
        logic [7:0] wdata;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [11:0] host_addr  = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        phy_req, phy_we;
    logic [7:0]  phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [7:0]  phy_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int phy_lat = 0;
    int lat_cnt = 0;
    int cycles = 0;
    logic [7:0] mem [256];
    logic [7:0] shadow [256];
    exp_item_t  expq [$];

    always #2 clk = ~clk;

    phy_reg_bridge i_phy_reg_bridge (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // PHY model
    always @(posedge clk) begin
        if (rst) begin
            phy_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (phy_req && !phy_ack) begin
            if (lat_cnt >= phy_lat) begin
                phy_ack   <= 1'b1;
                phy_rdata <= mem[phy_addr];
                if (phy_we) mem[phy_addr] <= phy_wdata;
                lat_cnt   <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            phy_ack <= 1'b0;
        end
    end

    // Scoreboard monitor: each completed PHY access is compared with the queue
    always @(negedge clk) begin
        if (!rst && phy_req && phy_ack) begin
            if (expq.size() == 0) begin
                chk("R9 unexpected PHY access", {23'd0, phy_we, phy_addr}, 32'hFFFF);
            end else begin
                exp_item_t e;
                e = expq.pop_front();
                chk("R4/R5 access direction", {31'd0, phy_we}, {31'd0, e.we});
                chk("R6 access offset", {24'd0, phy_addr}, {24'd0, e.addr});
                if (e.we) chk("R10 access write byte", {24'd0, phy_wdata}, {24'd0, e.wdata});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
        end
    end

    task automatic host_wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic host_rd(input logic [11:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        host_rd(CMD_OFS, v);
        while (v[9]) begin
            @(negedge clk);
            host_rd(CMD_OFS, v);
        end
    endtask

    task automatic drv_write(input logic [7:0] ofs, input logic [7:0] d);
        exp_item_t e;
        e.we = 1'b1; e.addr = ofs; e.wdata = d;
        expq.push_back(e);
        shadow[ofs] = d;
        host_wr(DAT_OFS, {8'hEE, d});
        host_wr(CMD_OFS, {7'd0, 1'b1, ofs});
        wait_idle();
    endtask

    task automatic drv_read(input logic [7:0] ofs);
        exp_item_t e;
        logic [15:0] v;
        e.we = 1'b0; e.addr = ofs; e.wdata = '0;
        expq.push_back(e);
        host_wr(CMD_OFS, {8'd0, ofs});
        wait_idle();
        host_rd(DAT_OFS, v);
        chk("R8 read data", {16'd0, v}, {24'd0, shadow[ofs]});
    endtask

    initial begin
        logic [15:0] v;
        exp_item_t e;
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        host_rd(CMD_OFS, v); chk("R1 command reg", {16'd0, v}, 32'h0);
        host_rd(DAT_OFS, v); chk("R1 data reg", {16'd0, v}, 32'h0);
        chk("R1 phy_req", {31'd0, phy_req}, 32'h0);

        // R2 / R3 register map
        host_wr(DAT_OFS, 16'hABCD);
        host_rd(DAT_OFS, v); chk("R3 data low byte only", {16'd0, v}, 32'h00CD);
        host_rd(12'h308, v); chk("R2 unmapped offset", {16'd0, v}, 32'h0);

        // R4 write launch, bit 9 written high has no effect
        phy_lat = 2;
        host_wr(DAT_OFS, 16'h005A);
        e.we = 1'b1; e.addr = 8'h12; e.wdata = 8'h5A; expq.push_back(e);
        shadow[8'h12] = 8'h5A;
        host_wr(CMD_OFS, 16'h0312);
        chk("R4 phy_req", {31'd0, phy_req}, 32'h1);
        chk("R4 phy_we", {31'd0, phy_we}, 32'h1);
        chk("R4 phy_addr", {24'd0, phy_addr}, 32'h12);
        chk("R4 phy_wdata", {24'd0, phy_wdata}, 32'h5A);
        host_rd(CMD_OFS, v); chk("R2 busy readback", {16'd0, v}, 32'h0312);
        wait_idle();
        host_rd(CMD_OFS, v); chk("R2 idle readback", {16'd0, v}, 32'h0112);

        // R5 read launch, then R7 busy drop timing
        phy_lat = 3;
        e.we = 1'b0; e.addr = 8'h40; e.wdata = '0; expq.push_back(e);
        host_wr(CMD_OFS, 16'h0040);
        chk("R5 phy_req", {31'd0, phy_req}, 32'h1);
        chk("R5 phy_we", {31'd0, phy_we}, 32'h0);
        chk("R5 phy_addr", {24'd0, phy_addr}, 32'h40);
        while (!phy_ack) @(negedge clk);
        host_rd(CMD_OFS, v); chk("R6 busy during ack cycle", {31'd0, v[9]}, 32'h1);
        @(negedge clk);
        host_rd(CMD_OFS, v); chk("R7 busy cleared", {31'd0, v[9]}, 32'h0);
        chk("R7 req cleared", {31'd0, phy_req}, 32'h0);
        host_rd(DAT_OFS, v); chk("R8 read capture", {16'd0, v}, {24'd0, shadow[8'h40]});

        // R9 / R10 writes during a running write
        phy_lat = 6;
        host_wr(DAT_OFS, 16'h0011);
        e.we = 1'b1; e.addr = 8'h20; e.wdata = 8'h11; expq.push_back(e);
        shadow[8'h20] = 8'h11;
        host_wr(CMD_OFS, 16'h0120);
        host_wr(CMD_OFS, 16'h0033);
        host_wr(DAT_OFS, 16'h0099);
        chk("R9 offset kept", {24'd0, phy_addr}, 32'h20);
        chk("R9 direction kept", {31'd0, phy_we}, 32'h1);
        chk("R10 write byte kept", {24'd0, phy_wdata}, 32'h11);
        host_rd(CMD_OFS, v); chk("R9 command reg kept", {16'd0, v}, 32'h0320);
        wait_idle();
        host_rd(DAT_OFS, v); chk("R10 data reg updated", {16'd0, v}, 32'h0099);
        drv_read(8'h20);
        drv_read(8'h33);

        // Varied offsets and latencies
        for (int k = 0; k < 8; k++) begin
            phy_lat = k % 4;
            drv_write(8'(k * 37 + 1), 8'(8'hC0 ^ k));
            drv_read(8'(k * 37 + 1));
        end
        phy_lat = 0;
        drv_read(8'h00);
        drv_read(8'hFF);
        drv_write(8'hFF, 8'h00);
        drv_read(8'hFF);

        repeat (4) @(negedge clk);
        chk("R9 no leftover expected accesses", expq.size(), 32'h0);
        summary();
    end
endmodule